// File: doc/BRIEF.md
# Time-Scheduled Square-Wave Output

This block turns a free-running 64-bit time value into a square wave whose edges fall on exact points of that time base. Software loads a 64-bit start time and a 64-bit half-period, both in raw time units, and then sets a run bit in the control word. When the time value reaches the start time the output level flips. The next flip is scheduled at the previous scheduled time plus the half-period. Edges are therefore locked to the time base rather than to a divided clock. A pulse-per-second output, for example, uses a half-period equal to half a second expressed in the time base's units.

Each level change can raise a one-cycle interrupt pulse. A two-bit pin setup word selects whether the block owns the pin: the output enable is active only when the pin is set as an output and is routed to this function. Clearing the run bit forces the level low at once. The intended sequence is to clear the control word, reprogram the start time and half-period, and set the control word last.

Top module: `tgclk_out`

## Requirements
- R1: While reset is high and on the first cycle after it, pin_level, pin_oe and edge_irq are low, and every stored word is zero.
- R2: Word addresses: 0 and 1 hold the low and high halves of the start time, 2 and 3 hold the low and high halves of the half-period, 4 holds the control word, and 5 holds the pin setup word. A write to any other address changes nothing.
- R3: pin_oe is high exactly when pin setup bit 0 (output direction) and bit 1 (routed to this function) are both set.
- R4: With control bit 0 (run) and bit 1 (align to start time) set, the level holds until the clock edge following the first cycle in which time_now is at or above the start time. At that edge it flips.
- R5: After each flip the next flip is scheduled at the previous scheduled time plus the half-period held at that flip, taken modulo 2^64.
- R6: time_now and the scheduled time are compared as unsigned 64-bit numbers, so a start time with bit 63 set is not reached by a time value with bit 63 clear.
- R7: With run set and align clear, the first flip occurs at the clock edge after the control write. The next flip is scheduled at the time_now value seen at the control write plus the half-period.
- R8: When control bit 2 is set, edge_irq is high for exactly the cycle in which the new level first appears after each flip. When bit 2 is clear, edge_irq stays low.
- R9: A control write with bit 0 clear drives pin_level low at that clock edge, raises no interrupt, and stops further flips.
- R10: Writes to the start-time words while running do not move the active schedule. They take effect only at the next control write.
- R11: If time_now is already past several scheduled flips, the level flips once per clock until the schedule passes time_now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current value of the running time counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| pin_level | output | 1 | Square-wave level |
| pin_oe | output | 1 | The block drives the pin |
| edge_irq | output | 1 | One-cycle pulse on each level flip |

## Verification
The assertions check the following on every cycle: the quiet reset state, that a flip never happens before time_now has reached the scheduled time, that an interrupt always comes with a level change, that a stop write pulls the level low, and that start-time writes leave a running schedule alone. The exact edge times cannot be seen from a single cycle's relations and are left to the bench's scenarios. These include the half-period stepping, the unsigned compare near bit 63, the free-start phase, catch-up after a time jump and the ignored address.

// File: rtl/tgclk_pkg.sv
package tgclk_pkg;

    // Control word: bit 0 run, bit 1 align to start time, bit 2 interrupt on flip
    typedef struct packed {
        logic irq_on_flip;
        logic align_start;
        logic run;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    // Pin setup word: bit 0 output direction, bit 1 routed to this block
    typedef struct packed {
        logic routed;
        logic dir_out;
    } pincfg_t;

    localparam int PIN_BITS = $bits(pincfg_t);

    function automatic logic owns_pin(input pincfg_t p);
        return p.dir_out & p.routed;
    endfunction

endpackage

// File: rtl/tgclk_regs.sv
module tgclk_regs
    import tgclk_pkg::*;
#(
    parameter int TW = 64,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [TW-1:0] start_o,
    output logic [TW-1:0] half_o,
    output ctrl_t         ctrl_o,
    output pincfg_t       pin_o,
    output logic          ctrl_wr_o,
    output ctrl_t         ctrl_new_o
);
    localparam int NW        = TW / DW;
    localparam int HALF_BASE = NW;
    localparam int CTRL_ADDR = 2 * NW;
    localparam int PIN_ADDR  = 2 * NW + 1;

    generate
        for (genvar w = 0; w < NW; w++) begin : g_word
            logic [DW-1:0] start_q;
            logic [DW-1:0] half_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    start_q <= '0;
                    half_q  <= '0;
                end else if (wr_en) begin
                    if (wr_addr == AW'(w))
                        start_q <= wr_data;
                    if (wr_addr == AW'(HALF_BASE + w))
                        half_q <= wr_data;
                end
            end
            assign start_o[w*DW +: DW] = start_q;
            assign half_o[w*DW +: DW]  = half_q;
        end
    endgenerate

    ctrl_t   ctrl_q;
    pincfg_t pin_q;

    assign ctrl_wr_o  = wr_en && (wr_addr == AW'(CTRL_ADDR));
    assign ctrl_new_o = ctrl_t'(wr_data[CTRL_BITS-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pin_q  <= '0;
        end else begin
            if (ctrl_wr_o)
                ctrl_q <= ctrl_new_o;
            if (wr_en && wr_addr == AW'(PIN_ADDR))
                pin_q <= pincfg_t'(wr_data[PIN_BITS-1:0]);
        end
    end

    assign ctrl_o = ctrl_q;
    assign pin_o  = pin_q;
endmodule

// File: rtl/tgclk_sched.sv
module tgclk_sched #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] time_now,
    input  logic [TW-1:0] start_t,
    input  logic [TW-1:0] half_t,
    input  logic          run,
    input  logic          ctrl_wr,
    input  logic          new_align,
    output logic [TW-1:0] edge_o,
    output logic          fire_o
);
    logic [TW-1:0] edge_q;

    // unsigned compare; a control write takes precedence over a flip
    assign fire_o = run && !ctrl_wr && (time_now >= edge_q);

    always_ff @(posedge clk) begin
        if (rst)
            edge_q <= '0;
        else if (ctrl_wr)
            edge_q <= new_align ? start_t : time_now;
        else if (fire_o)
            edge_q <= edge_q + half_t;
    end

    assign edge_o = edge_q;
endmodule

// File: rtl/tgclk_drive.sv
module tgclk_drive
    import tgclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  logic    stop,
    input  logic    irq_en,
    input  pincfg_t pin_cfg,
    output logic    level_o,
    output logic    oe_o,
    output logic    irq_o
);
    logic level_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            level_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (fire)
                level_q <= !level_q;
            irq_q <= fire && irq_en;
        end
    end

    assign level_o = level_q;
    assign irq_o   = irq_q;
    assign oe_o    = owns_pin(pin_cfg);
endmodule

// File: rtl/tgclk_out.sv
module tgclk_out
    import tgclk_pkg::*;
#(
    parameter int TW = 64,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] time_now,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pin_level,
    output logic          pin_oe,
    output logic          edge_irq
);
    logic [TW-1:0] start_t;
    logic [TW-1:0] half_t;
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    pincfg_t       pin_q;
    logic          ctrl_wr;
    logic [TW-1:0] sched_edge;
    logic          fire;
    logic          run_now;
    logic          stop_now;

    assign run_now  = ctrl_q.run;
    assign stop_now = ctrl_wr && !ctrl_new.run;

    tgclk_regs #(.TW(TW), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start_o   (start_t),
        .half_o    (half_t),
        .ctrl_o    (ctrl_q),
        .pin_o     (pin_q),
        .ctrl_wr_o (ctrl_wr),
        .ctrl_new_o(ctrl_new)
    );

    tgclk_sched #(.TW(TW)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .time_now (time_now),
        .start_t  (start_t),
        .half_t   (half_t),
        .run      (run_now),
        .ctrl_wr  (ctrl_wr),
        .new_align(ctrl_new.align_start),
        .edge_o   (sched_edge),
        .fire_o   (fire)
    );

    tgclk_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .stop   (stop_now),
        .irq_en (ctrl_q.irq_on_flip),
        .pin_cfg(pin_q),
        .level_o(pin_level),
        .oe_o   (pin_oe),
        .irq_o  (edge_irq)
    );
endmodule

// File: rtl/tgclk_out_chk.sv
module tgclk_out_chk #(
    parameter int TW = 64,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    wr_low,
    input logic [TW-1:0] time_now,
    input logic          pin_level,
    input logic          pin_oe,
    input logic          edge_irq,
    input logic [TW-1:0] sched_edge,
    input logic          fire,
    input logic          run_now
);
    localparam int NW        = TW / DW;
    localparam int CTRL_ADDR = 2 * NW;
    localparam int PIN_ADDR  = 2 * NW + 1;

    logic stop_w;
    logic start_w;
    assign stop_w  = wr_en && (wr_addr == AW'(CTRL_ADDR)) && !wr_low[0];
    assign start_w = wr_en && (wr_addr < AW'(NW));

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pin_level && !edge_irq && !pin_oe)); // R1

    AST_OE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(PIN_ADDR) && wr_low == 2'b11) |=> pin_oe); // R3

    AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (rst)
        ((pin_level != $past(pin_level)) && !$past(stop_w))
            |-> $past(run_now && (time_now >= sched_edge))); // R4

    AST_IRQ_WITH_FLIP: assert property (@(posedge clk) disable iff (rst)
        edge_irq |-> (pin_level != $past(pin_level))); // R8

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        stop_w |=> (!pin_level && !edge_irq)); // R9

    AST_SCHEDULE_HELD: assert property (@(posedge clk) disable iff (rst)
        (start_w && !fire) |=> $stable(sched_edge)); // R10
endmodule

bind tgclk_out tgclk_out_chk #(.TW(TW), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_low    (wr_data[1:0]),
    .time_now  (time_now),
    .pin_level (pin_level),
    .pin_oe    (pin_oe),
    .edge_irq  (edge_irq),
    .sched_edge(sched_edge),
    .fire      (fire),
    .run_now   (run_now)
);

// File: tb/tgclk_out_bench.sv
`timescale 1ns/1ps
module tgclk_out_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tnow = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pin_level, pin_oe, edge_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tgclk_out u_tgclk_out (
        .clk(clk), .rst(rst), .time_now(tnow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_level(pin_level), .pin_oe(pin_oe), .edge_irq(edge_irq)
    );

    // behavioural reference model
    logic [63:0] m_start, m_half, m_next;
    bit m_run, m_align, m_ien, m_dir, m_routed, m_lvl, m_irq;

    always @(posedge clk) begin : model
        bit is_ctrl, flip;
        if (rst) begin
            m_start = 0; m_half = 0; m_next = 0;
            m_run = 0; m_align = 0; m_ien = 0; m_dir = 0; m_routed = 0;
            m_lvl = 0; m_irq = 0;
        end else begin
            is_ctrl = wr_en && (wr_addr == 3'd4);
            flip    = m_run && !is_ctrl && (tnow >= m_next);
            m_irq   = flip && m_ien;
            if (flip) begin
                m_lvl  = !m_lvl;
                m_next = m_next + m_half;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_start[31:0]  = wr_data;
                    3'd1: m_start[63:32] = wr_data;
                    3'd2: m_half[31:0]   = wr_data;
                    3'd3: m_half[63:32]  = wr_data;
                    3'd4: begin
                        m_next  = wr_data[1] ? m_start : tnow;
                        m_run   = wr_data[0];
                        m_align = wr_data[1];
                        m_ien   = wr_data[2];
                        if (!wr_data[0]) begin m_lvl = 0; m_irq = 0; end
                    end
                    3'd5: begin m_dir = wr_data[0]; m_routed = wr_data[1]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 R5 R7 R9 R11 model level", {63'd0, pin_level}, {63'd0, m_lvl});
            chk("R3 model oe", {63'd0, pin_oe}, {63'd0, m_dir && m_routed});
            chk("R8 model irq", {63'd0, edge_irq}, {63'd0, m_irq});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [63:0] v);
        tnow = v;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int irqs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 level", {63'd0, pin_level}, 64'd0);
        chk("R1 oe", {63'd0, pin_oe}, 64'd0);
        chk("R1 irq", {63'd0, edge_irq}, 64'd0);

        wr(3'd5, 32'd1); chk("R3 dir only", {63'd0, pin_oe}, 64'd0);
        wr(3'd5, 32'd3); chk("R3 both", {63'd0, pin_oe}, 64'd1);
        wr(3'd5, 32'd2); chk("R3 routed only", {63'd0, pin_oe}, 64'd0);
        wr(3'd5, 32'd3);
        wr(3'd6, 32'd0); chk("R2 unused address", {63'd0, pin_oe}, 64'd1);

        // aligned start
        tnow = 64'd1000;
        wr(3'd0, 32'd2000); wr(3'd1, 32'd0); wr(3'd2, 32'd300); wr(3'd3, 32'd0);
        wr(3'd4, 32'd7);
        chk("R4 armed", {63'd0, pin_level}, 64'd0);
        tick(64'd1999); chk("R4 before start", {63'd0, pin_level}, 64'd0);
        tick(64'd2000); chk("R4 at start", {63'd0, pin_level}, 64'd1);
        chk("R8 pulse", {63'd0, edge_irq}, 64'd1);
        tick(64'd2000); chk("R8 single cycle", {63'd0, edge_irq}, 64'd0);
        tick(64'd2299); chk("R5 before step", {63'd0, pin_level}, 64'd1);
        tick(64'd2300); chk("R5 step", {63'd0, pin_level}, 64'd0);

        wr(3'd0, 32'd9000);
        tick(64'd2599); chk("R10 held", {63'd0, pin_level}, 64'd0);
        tick(64'd2600); chk("R10 old schedule", {63'd0, pin_level}, 64'd1);

        wr(3'd4, 32'd0);
        chk("R9 low", {63'd0, pin_level}, 64'd0);
        chk("R9 no irq", {63'd0, edge_irq}, 64'd0);
        tick(64'd100000); chk("R9 stays stopped", {63'd0, pin_level}, 64'd0);

        // catch-up
        tnow = 64'd50;
        wr(3'd0, 32'd100); wr(3'd2, 32'd10); wr(3'd4, 32'd7);
        irqs = 0;
        for (int i = 0; i < 5; i++) begin
            tick(64'd135);
            if (edge_irq) irqs++;
            if (i == 0) chk("R11 first", {63'd0, pin_level}, 64'd1);
        end
        chk("R11 flip count", 64'(irqs), 64'd4);
        chk("R11 settled", {63'd0, pin_level}, 64'd0);

        // unsigned compare
        wr(3'd4, 32'd0);
        tnow = 64'h7FFF_FFFF_FFFF_FFF0;
        wr(3'd0, 32'h10); wr(3'd1, 32'h8000_0000); wr(3'd4, 32'd7);
        tick(64'h7FFF_FFFF_FFFF_FFFF); chk("R6 not reached", {63'd0, pin_level}, 64'd0);
        tick(64'h8000_0000_0000_0010); chk("R6 reached", {63'd0, pin_level}, 64'd1);

        // free start
        wr(3'd4, 32'd0);
        tnow = 64'd5000;
        wr(3'd2, 32'd250); wr(3'd3, 32'd0); wr(3'd4, 32'd5);
        chk("R7 armed", {63'd0, pin_level}, 64'd0);
        tick(64'd5000); chk("R7 first flip", {63'd0, pin_level}, 64'd1);
        tick(64'd5249); chk("R7 hold", {63'd0, pin_level}, 64'd1);
        tick(64'd5250); chk("R7 phase", {63'd0, pin_level}, 64'd0);

        // interrupt disabled
        wr(3'd4, 32'd0);
        tnow = 64'd0;
        wr(3'd0, 32'd20); wr(3'd1, 32'd0); wr(3'd4, 32'd3);
        tick(64'd20);
        chk("R8 flip without irq", {63'd0, pin_level}, 64'd1);
        chk("R8 masked", {63'd0, edge_irq}, 64'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule